// File: doc/BRIEF.md
# Five-Channel Reloading Down-Counter Timer

This block holds a bank of independent 32-bit down counters. Each one is clocked by a tap of a shared free-running prescaler. When a channel's start bit is set, its counter drops by one on every tick of the tap it has selected. A tick that arrives while the counter holds zero does not wrap the counter. Instead it loads the channel's constant register and raises that channel's underflow flag. The flag stays set until software clears it.

Software reaches every register through a single-cycle word-addressed write port and a combinational read port. There are two synchronous active-low resets. The power-on reset clears everything. The manual reset clears the control state, but the upper channels (mask parameter, channels 3 and 4 by default) keep their counter and constant contents. A standby input freezes the prescaler, so all counting stops while every register keeps its value.

Top module: `reload_timer`

## Requirements
- R1: When a channel's start bit is 1, its counter decreases by one on each selected tick. When the start bit is 0, the counter holds its value.
- R2: Select code k in 0..4 (control bits [2:0]) ticks once every 4^(k+1) clock cycles. The tick comes in the cycle where the prescaler count, which is zero after either reset and advances by one per cycle, modulo 4^(k+1) equals 4^(k+1)-1. Codes 5, 6 and 7 never tick.
- R3: A tick that arrives while the counter is zero loads the channel's constant register value into the counter.
- R4: That same tick sets the channel's flag, which appears as control bit 3 and in `uf_flags[c]`.
- R5: Writing a control word with bit 3 at 0 clears the flag. Writing it with bit 3 at 1 leaves the flag as it is. If a clear and an underflow happen in the same cycle, the flag ends up set.
- R6: A bus write to a counter takes effect in the cycle it is made, and any tick in that same cycle is discarded.
- R7: Power-on reset sets every counter and constant register to all ones. It also clears the select fields, the flags, the start bits and the prescaler.
- R8: Manual reset sets the counters and constants of channels 0 to 2 to all ones. Channels 3 and 4 keep their counters and constants. The select fields, flags, start bits and prescaler are cleared on all channels, and bus writes made during manual reset are ignored.
- R9: While standby is high, the prescaler and all counters stay frozen and no register changes except through bus writes.
- R10: The register map uses word addresses. Address 0 holds the start bits in [4:0], with bit c for channel c. Channel c has its constant at 1+3c, its counter at 2+3c and its control at 3+3c. Unused addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| mrst_n | input | 1 | Synchronous manual reset, active low |
| standby | input | 1 | Freeze counting, keep all state |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| uf_flags | output | 5 | Per-channel underflow flags |

## Verification
A counter that skips a tick or takes an extra one shows up in its read value at once. The flag toggles a whole reload period early or late, so the error also surfaces at the next underflow, no later than 4^(k+1) times the constant plus one cycles after it occurs. A prescaler that slips its phase makes every active channel drift from the reference within one divide period. A channel placed in the wrong reset domain is caught in the first read after the manual reset. The bench sweeps the read address on every cycle and compares the read data and the flag vector against a behavioural model. It also forces writes and clears into the same cycles as ticks and underflows.

// File: rtl/rt_pkg.sv
package rt_pkg;
   localparam int SEL_W       = 3;
   localparam int FLAG_BIT    = 3;
   localparam int REGS_PER_CH = 3;

   typedef enum logic [1:0] {
      SLOT_CONST = 2'd0,
      SLOT_COUNT = 2'd1,
      SLOT_CTRL  = 2'd2
   } slot_e;

   function automatic int slot_addr(input int ch, input slot_e s);
      return 1 + REGS_PER_CH * ch + int'(s);
   endfunction
endpackage

// File: rtl/rt_prescale.sv
module rt_prescale #(
   parameter int NUM_DIV = 5,
   localparam int PRE_W  = 2 * NUM_DIV
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               mrst_n,
   input  logic               standby,
   output logic [PRE_W-1:0]   phase,
   output logic [NUM_DIV-1:0] div_tick
);
   always_ff @(posedge clk) begin
      if (!por_n || !mrst_n) phase <= '0;
      else if (!standby)     phase <= phase + 1'b1;
   end

   for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
      assign div_tick[k] = (&phase[2*k+1:0]) & ~standby;
   end
endmodule

// File: rtl/rt_channel.sv
module rt_channel
   import rt_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter int NUM_DIV      = 5,
   parameter bit KEEP_ON_MRST = 1'b0
) (
   input  logic               clk,
   input  logic               por_n,
   input  logic               mrst_n,
   input  logic [NUM_DIV-1:0] div_tick,
   input  logic               run,
   input  logic               we_const,
   input  logic               we_count,
   input  logic               we_ctrl,
   input  logic [CNT_W-1:0]   wdata,
   output logic [CNT_W-1:0]   count,
   output logic [CNT_W-1:0]   constant,
   output logic [SEL_W-1:0]   sel,
   output logic               flag,
   output logic               tick
);
   logic data_clr, data_hold, ctl_clr, tap, uf;

   if (KEEP_ON_MRST) begin : g_keep
      assign data_clr  = !por_n;
      assign data_hold = !mrst_n;
   end else begin : g_plain
      assign data_clr  = !por_n || !mrst_n;
      assign data_hold = 1'b0;
   end
   assign ctl_clr = !por_n || !mrst_n;

   always_comb begin
      tap = 1'b0;
      for (int k = 0; k < NUM_DIV; k++)
         if (sel == SEL_W'(k)) tap = div_tick[k];
   end

   assign tick = run & tap;
   assign uf   = tick && (count == '0) && !we_count;

   always_ff @(posedge clk) begin
      if (data_clr) begin
         count    <= '1;
         constant <= '1;
      end else if (!data_hold) begin
         if (we_count)  count <= wdata;
         else if (tick) count <= (count == '0) ? constant : count - 1'b1;
         if (we_const)  constant <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (ctl_clr) begin
         sel  <= '0;
         flag <= 1'b0;
      end else begin
         if (we_ctrl) sel <= wdata[SEL_W-1:0];
         if (uf)                            flag <= 1'b1;
         else if (we_ctrl && !wdata[FLAG_BIT]) flag <= 1'b0;
      end
   end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
   import rt_pkg::*;
#(
   parameter int           NUM_CH    = 5,
   parameter int           CNT_W     = 32,
   parameter int           ADDR_W    = 5,
   parameter int           NUM_DIV   = 5,
   parameter logic [NUM_CH-1:0] KEEP_MASK = 5'b11000
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              standby,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   output logic [NUM_CH-1:0] uf_flags
);
   localparam int PRE_W  = 2 * NUM_DIV;
   localparam int N_REGS = 1 + REGS_PER_CH * NUM_CH;

   if (N_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("reload_timer: ADDR_W too small for the register map");
   end
   if (CNT_W < NUM_CH || CNT_W <= FLAG_BIT) begin : g_bad_width
      $error("reload_timer: CNT_W too small");
   end
   if (NUM_DIV < 1 || NUM_DIV > (1 << SEL_W)) begin : g_bad_div
      $error("reload_timer: NUM_DIV out of range");
   end

   logic [PRE_W-1:0]               phase;
   logic [NUM_DIV-1:0]             div_tick;
   logic [NUM_CH-1:0]              start_q;
   logic [NUM_CH-1:0]              cnt_we, const_we, ctrl_we;
   logic [NUM_CH-1:0][CNT_W-1:0]   cnt_q, const_q;
   logic [NUM_CH-1:0][SEL_W-1:0]   sel_q;
   logic [NUM_CH-1:0]              flag_q, ch_tick;
   logic                           we_ok;

   assign we_ok = bus_we && por_n && mrst_n;

   rt_prescale #(.NUM_DIV(NUM_DIV)) u_pre (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby),
      .phase(phase), .div_tick(div_tick)
   );

   always_comb begin
      for (int c = 0; c < NUM_CH; c++) begin
         const_we[c] = we_ok && (bus_addr == ADDR_W'(slot_addr(c, SLOT_CONST)));
         cnt_we[c]   = we_ok && (bus_addr == ADDR_W'(slot_addr(c, SLOT_COUNT)));
         ctrl_we[c]  = we_ok && (bus_addr == ADDR_W'(slot_addr(c, SLOT_CTRL)));
      end
   end

   always_ff @(posedge clk) begin
      if (!por_n || !mrst_n)           start_q <= '0;
      else if (we_ok && bus_addr == '0) start_q <= bus_wdata[NUM_CH-1:0];
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      rt_channel #(
         .CNT_W(CNT_W), .NUM_DIV(NUM_DIV), .KEEP_ON_MRST(KEEP_MASK[c])
      ) u_ch (
         .clk(clk), .por_n(por_n), .mrst_n(mrst_n),
         .div_tick(div_tick), .run(start_q[c]),
         .we_const(const_we[c]), .we_count(cnt_we[c]), .we_ctrl(ctrl_we[c]),
         .wdata(bus_wdata),
         .count(cnt_q[c]), .constant(const_q[c]), .sel(sel_q[c]),
         .flag(flag_q[c]), .tick(ch_tick[c])
      );
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == '0) bus_rdata[NUM_CH-1:0] = start_q;
      for (int c = 0; c < NUM_CH; c++) begin
         if (bus_addr == ADDR_W'(slot_addr(c, SLOT_CONST))) bus_rdata = const_q[c];
         if (bus_addr == ADDR_W'(slot_addr(c, SLOT_COUNT))) bus_rdata = cnt_q[c];
         if (bus_addr == ADDR_W'(slot_addr(c, SLOT_CTRL))) begin
            bus_rdata[SEL_W-1:0] = sel_q[c];
            bus_rdata[FLAG_BIT]  = flag_q[c];
         end
      end
   end

   assign uf_flags = flag_q;
endmodule

// File: rtl/rt_checker.sv
module rt_checker #(
   parameter int NUM_CH  = 5,
   parameter int CNT_W   = 32,
   parameter int NUM_DIV = 5,
   parameter logic [NUM_CH-1:0] KEEP_MASK = 5'b11000
) (
   input logic                         clk,
   input logic                         por_n,
   input logic                         mrst_n,
   input logic                         standby,
   input logic [NUM_CH-1:0]            start_q,
   input logic [NUM_CH-1:0]            cnt_we,
   input logic [NUM_CH-1:0]            ch_tick,
   input logic [NUM_CH-1:0]            flag_q,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt_q,
   input logic [NUM_CH-1:0][CNT_W-1:0] const_q,
   input logic [2*NUM_DIV-1:0]         phase,
   input logic [CNT_W-1:0]             bus_wdata
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      assert_stopped_hold_R1: assert property (@(posedge clk) disable iff (!por_n)
         (mrst_n && !start_q[c] && !cnt_we[c]) |=> $stable(cnt_q[c]));

      assert_reload_R3: assert property (@(posedge clk) disable iff (!por_n)
         (mrst_n && ch_tick[c] && cnt_q[c] == '0 && !cnt_we[c])
            |=> cnt_q[c] == $past(const_q[c]));

      assert_flag_set_R4: assert property (@(posedge clk) disable iff (!por_n)
         (mrst_n && ch_tick[c] && cnt_q[c] == '0 && !cnt_we[c]) |=> flag_q[c]);

      assert_write_wins_R6: assert property (@(posedge clk) disable iff (!por_n)
         (mrst_n && cnt_we[c]) |=> cnt_q[c] == $past(bus_wdata));

      if (KEEP_MASK[c]) begin : g_keep
         assert_keep_mrst_R8: assert property (@(posedge clk) disable iff (!por_n)
            !mrst_n |=> ($stable(cnt_q[c]) && $stable(const_q[c])));
      end
   end

   assert_standby_freeze_R9: assert property (@(posedge clk) disable iff (!por_n)
      (mrst_n && standby) |=> $stable(phase));
endmodule

bind reload_timer rt_checker #(
   .NUM_CH(NUM_CH), .CNT_W(CNT_W), .NUM_DIV(NUM_DIV), .KEEP_MASK(KEEP_MASK)
) u_chk (
   .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby),
   .start_q(start_q), .cnt_we(cnt_we), .ch_tick(ch_tick), .flag_q(flag_q),
   .cnt_q(cnt_q), .const_q(const_q), .phase(phase), .bus_wdata(bus_wdata)
);

// File: tb/tb_reload_timer.sv
`timescale 1ns/1ps
module tb_reload_timer;
   localparam int NCH = 5;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, mrst_n = 1'b1, standby = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  uf_flags;

   always #2.5 clk = ~clk;

   reload_timer dut (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .uf_flags(uf_flags)
   );

   // behavioural reference
   int          m_pre;
   logic [31:0] m_cnt [NCH];
   logic [31:0] m_con [NCH];
   logic [2:0]  m_sel [NCH];
   bit          m_flag[NCH];
   bit   [4:0]  m_start;
   bit          armed = 0;
   int          n_vec = 0, n_bad = 0;
   int          sweep = 0;

   always @(posedge clk) begin
      if (!por_n || !mrst_n) begin
         for (int c = 0; c < NCH; c++) begin
            if (!por_n || c < 3) begin
               m_cnt[c] = 32'hFFFF_FFFF;
               m_con[c] = 32'hFFFF_FFFF;
            end
            m_sel[c]  = 3'd0;
            m_flag[c] = 0;
         end
         m_start = '0;
         m_pre   = 0;
      end else begin
         int  pold;
         bit  t [NCH];
         pold = m_pre;
         for (int c = 0; c < NCH; c++) begin
            int d;
            d    = 4 << (2 * m_sel[c]);
            t[c] = m_start[c] && (m_sel[c] < 5) && !standby && ((pold % d) == d - 1);
         end
         if (!standby) m_pre = (m_pre + 1) % 1024;
         for (int c = 0; c < NCH; c++) begin
            bit wk, wn, wt, uf;
            wk = bus_we && bus_addr == 5'(1 + 3*c);
            wn = bus_we && bus_addr == 5'(2 + 3*c);
            wt = bus_we && bus_addr == 5'(3 + 3*c);
            uf = t[c] && m_cnt[c] == 0 && !wn;
            if (wn)        m_cnt[c] = bus_wdata;
            else if (t[c]) m_cnt[c] = (m_cnt[c] == 0) ? m_con[c] : m_cnt[c] - 1;
            if (wk) m_con[c] = bus_wdata;
            if (wt) m_sel[c] = bus_wdata[2:0];
            if (uf) m_flag[c] = 1;
            else if (wt && !bus_wdata[3]) m_flag[c] = 0;
         end
         if (bus_we && bus_addr == 0) m_start = bus_wdata[4:0];
      end
      armed = 1;
   end

   function automatic logic [31:0] exp_rd(input logic [4:0] a);
      if (a == 0) return {27'd0, m_start};
      for (int c = 0; c < NCH; c++) begin
         if (a == 5'(1 + 3*c)) return m_con[c];
         if (a == 5'(2 + 3*c)) return m_cnt[c];
         if (a == 5'(3 + 3*c)) return {28'd0, m_flag[c], m_sel[c]};
      end
      return 32'd0;
   endfunction

   function automatic string tag_of(input logic [4:0] a);
      if (a == 0)  return "R10 start";
      if (a > 15)  return "R10 unused";
      case ((a - 1) % 3)
         0:       return "R3 R10 constant";
         1:       return "R1 R2 R6 counter";
         default: return "R4 R5 control";
      endcase
   endfunction

   function automatic logic [4:0] exp_flags();
      logic [4:0] f;
      for (int c = 0; c < NCH; c++) f[c] = m_flag[c];
      return f;
   endfunction

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (armed) begin
         n_vec++;
         if (bus_rdata !== exp_rd(bus_addr)) begin
            n_bad++;
            $display("FAIL %s addr %0d: got %h expected %h (std=%0b mrst=%0b)",
                     tag_of(bus_addr), bus_addr, bus_rdata, exp_rd(bus_addr), standby, mrst_n);
         end
         n_vec++;
         if (uf_flags !== exp_flags()) begin
            n_bad++;
            $display("FAIL R4 R5 flags: got %b expected %b", uf_flags, exp_flags());
         end
      end
   end

   task automatic cyc(input bit we, input int a, input logic [31:0] d);
      @(negedge clk); #1;
      bus_we = we; bus_addr = 5'(a); bus_wdata = d;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      cyc(1, a, d);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         cyc(0, sweep, 0);
         sweep = (sweep + 1) % 18;
      end
   endtask

   // directed read of a literal expectation, in the current cycle
   task automatic chk(input int a, input logic [31:0] e, input string tag);
      cyc(0, a, 0);
      #0.5;
      n_vec++;
      if (bus_rdata !== e) begin
         n_bad++;
         $display("FAIL %s addr %0d: got %h expected %h", tag, a, bus_rdata, e);
      end
   endtask

   bit done = 0;

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      por_n = 0;
      idle(3);
      cyc(0, 0, 0); por_n = 1;
      chk(2, 32'hFFFF_FFFF, "R7 counter after power-on");
      chk(13, 32'hFFFF_FFFF, "R7 constant after power-on");
      chk(3, 32'h0, "R7 control after power-on");
      chk(0, 32'h0, "R7 start after power-on");

      // channel set-up (R10 map)
      wr(1, 5);   wr(2, 3);    wr(3, 0);        // ch0 div4
      wr(4, 2);   wr(5, 2);    wr(6, 1);        // ch1 div16
      wr(7, 7);   wr(8, 1);    wr(9, 6);        // ch2 code 6: stopped (R2)
      wr(10, 9);  wr(11, 4);   wr(12, 0);       // ch3 div4
      wr(13, 1000); wr(14, 1); wr(15, 2);       // ch4 div64
      wr(0, 32'h1F);
      chk(9, 32'h6, "R2 code 6 select readback");
      idle(600);
      chk(8, 32'h1, "R2 code 6 never ticks");

      // R5: write-1 leaves flag, repeated clears collide with underflows
      wr(3, 32'h8);
      for (int i = 0; i < 60; i++) wr(3, 32'h0);
      idle(50);
      // R6: counter writes collide with ticks
      for (int i = 0; i < 20; i++) wr(2, 32'd100 + i);
      idle(50);

      // R9: standby freezes counting, writes still land
      standby = 1;
      idle(40);
      wr(13, 32'd50);
      idle(60);
      chk(13, 32'd50, "R9 write during standby");
      standby = 0;
      idle(100);

      // R1: stop ch1
      wr(0, 32'h1D);
      idle(120);

      // R8: manual reset domains
      wr(10, 32'h0000_ABCD);
      wr(1, 32'h0000_1234);
      cyc(0, 0, 0); mrst_n = 0;
      wr(10, 32'h0000_0BAD);                   // ignored during manual reset
      idle(2);
      cyc(0, 0, 0); mrst_n = 1;
      chk(10, 32'h0000_ABCD, "R8 ch3 constant kept");
      chk(1, 32'hFFFF_FFFF, "R8 ch0 constant cleared");
      chk(12, 32'h0, "R8 ch3 control cleared");
      chk(0, 32'h0, "R8 start cleared");
      wr(0, 32'h1F);
      wr(12, 0);
      idle(300);

      // R7: power-on reset clears the kept channels too
      cyc(0, 0, 0); por_n = 0;
      idle(2);
      cyc(0, 0, 0); por_n = 1;
      chk(10, 32'hFFFF_FFFF, "R7 ch3 constant after power-on");
      chk(14, 32'hFFFF_FFFF, "R7 ch4 counter after power-on");
      wr(2, 0); wr(1, 3); wr(0, 32'h01);
      idle(200);

      done = 1;
      @(negedge clk); #1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule